// File: doc/BRIEF.md
# Predicated Vector Result Writeback

This block is the last stage of a wide SIMD result path. Each cycle it may accept a freshly computed result vector together with the current contents of the destination register. It then decides, element by element, whether the new value is written or the destination keeps its old value. Predication comes from a small bank of eight mask registers. A 3-bit selector picks the register that acts as the predicate, and a mode flag chooses zeroing or merging for lanes whose predicate bit is clear.

The element width sets how many predicate bits take part. Element i of the vector is governed by bit i of the selected mask register. Bits past the last element count are never looked at. Selector 0 does not read mask register 0. It means "all lanes on". Register 0 is still ordinary storage, and the mask write and read ports reach it like any other register. The merged vector appears one clock after the input is accepted.

Top module: `vec_lane_mask_wb`

## Requirements
- R1: With selector values 1 to 7, bit i of mask register <selector> enables element i of the result.
- R2: With selector value 0, every element takes the result value, whatever mask register 0 holds.
- R3: Mask register 0 is real storage. A write to it through the mask write port can be read back on the mask read port.
- R4: In zeroing mode (`in_zero`=1), every byte of a disabled element is output as 0.
- R5: In merging mode (`in_zero`=0), every byte of a disabled element is output as the corresponding byte of `in_old`.
- R6: The element width code is `in_ew`: 0 selects 8-bit, 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit elements. Byte b belongs to element b >> `in_ew`, so a full 512-bit vector uses 64, 32, 16 or 8 mask bits.
- R7: Mask bits at or above the element count for the current width have no effect on the output.
- R8: `out_valid` is high exactly one cycle after `in_valid`, and `out_vec` then carries that input's merged vector. `out_vec` holds its value when no input is accepted.
- R9: A mask register written in the same cycle that it serves as the predicate, or is read on the read port, supplies its old value in that cycle. The new value is visible from the next cycle on.
- R10: After reset, `out_valid` is 0, `out_vec` is 0 and all eight mask registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept a result this cycle |
| in_result | input | VEC_W | Computed result vector |
| in_old | input | VEC_W | Current destination contents |
| in_ew | input | 2 | Element width code |
| in_msel | input | 3 | Predicate selector, 0 = unmasked |
| in_zero | input | 1 | 1 = zero disabled lanes, 0 = merge |
| mw_en | input | 1 | Mask register write enable |
| mw_idx | input | 3 | Mask register to write |
| mw_data | input | MREG_W | Mask write data |
| mr_idx | input | 3 | Mask register to read |
| mr_data | output | MREG_W | Mask read data (combinational) |
| out_valid | output | 1 | Merged vector valid |
| out_vec | output | VEC_W | Merged destination vector |

## Verification
The bench builds the block with VEC_W=64 and MREG_W=8, so one vector has eight byte lanes. This makes every 8-bit mask value reachable. For each of the 256 mask patterns, it sweeps all four element widths, all eight selectors and both modes, which covers the bit-to-element mapping and the ignored upper bits in full. The 64-bit width then leaves seven unused mask bits, and the bench sets them deliberately. Directed cases cover register 0 against selector 0, and a write that collides with a predicate read and a port read.

// File: rtl/vec_lane_mask_wb.sv
module vec_lane_mask_wb #(
  parameter int VEC_W  = 512,
  parameter int MREG_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  in_result,
  input  logic [VEC_W-1:0]  in_old,
  input  logic [1:0]        in_ew,
  input  logic [2:0]        in_msel,
  input  logic              in_zero,
  input  logic              mw_en,
  input  logic [2:0]        mw_idx,
  input  logic [MREG_W-1:0] mw_data,
  input  logic [2:0]        mr_idx,
  output logic [MREG_W-1:0] mr_data,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_vec
);
  localparam int NBYTES = VEC_W / 8;
  localparam int IDXW   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int NMREG  = 8;

  logic [MREG_W-1:0] mreg [NMREG];
  logic [MREG_W-1:0] pred;
  logic [NBYTES-1:0] lane_en;
  logic [VEC_W-1:0]  merged;

  assign pred    = mreg[in_msel];
  assign mr_data = mreg[mr_idx];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [IDXW-1:0] elem;
    assign elem       = IDXW'(b) >> in_ew;
    assign lane_en[b] = (in_msel == 3'd0) | pred[elem];
    assign merged[8*b +: 8] = lane_en[b] ? in_result[8*b +: 8]
                            : (in_zero ? 8'h00 : in_old[8*b +: 8]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NMREG; i++) mreg[i] <= '0;
    end else if (mw_en) begin
      mreg[mw_idx] <= mw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= merged;
    end
  end
endmodule

// File: rtl/vec_lane_mask_wb_chk.sv
module vec_lane_mask_wb_chk #(
  parameter int VEC_W  = 512,
  parameter int MREG_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [VEC_W-1:0]  in_result,
  input logic [VEC_W-1:0]  in_old,
  input logic [2:0]        in_msel,
  input logic              in_zero,
  input logic              mw_en,
  input logic [2:0]        mw_idx,
  input logic [MREG_W-1:0] mw_data,
  input logic [2:0]        mr_idx,
  input logic [MREG_W-1:0] mr_data,
  input logic              out_valid,
  input logic [VEC_W-1:0]  out_vec
);
  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec));
  p_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_msel == 3'd0) |=> out_vec == $past(in_result));
  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zero && in_result == '0) |=> out_vec == '0);
  p_merge_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_zero && in_result == in_old) |=> out_vec == $past(in_old));
  p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_en && mw_idx == mr_idx) |=> ($stable(mr_idx) -> mr_data == $past(mw_data)));
endmodule

bind vec_lane_mask_wb vec_lane_mask_wb_chk #(.VEC_W(VEC_W), .MREG_W(MREG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_result(in_result),
  .in_old(in_old), .in_msel(in_msel), .in_zero(in_zero), .mw_en(mw_en),
  .mw_idx(mw_idx), .mw_data(mw_data), .mr_idx(mr_idx), .mr_data(mr_data),
  .out_valid(out_valid), .out_vec(out_vec)
);

// File: tb/vec_lane_mask_wb_bench.sv
module vec_lane_mask_wb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 64;
  localparam int MW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_result = '0;
  logic [VW-1:0] in_old = '0;
  logic [1:0]    in_ew = '0;
  logic [2:0]    in_msel = '0;
  logic          in_zero = 1'b0;
  logic          mw_en = 1'b0;
  logic [2:0]    mw_idx = '0;
  logic [MW-1:0] mw_data = '0;
  logic [2:0]    mr_idx = '0;
  logic [MW-1:0] mr_data;
  logic          out_valid;
  logic [VW-1:0] out_vec;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [MW-1:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_lane_mask_wb #(.VEC_W(VW), .MREG_W(MW)) u_vec_lane_mask_wb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_result(in_result),
    .in_old(in_old), .in_ew(in_ew), .in_msel(in_msel), .in_zero(in_zero),
    .mw_en(mw_en), .mw_idx(mw_idx), .mw_data(mw_data), .mr_idx(mr_idx),
    .mr_data(mr_data), .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic logic [VW-1:0] expect_vec(logic [VW-1:0] res, logic [VW-1:0] old,
      int ew, int sel, bit zero, logic [MW-1:0] m);
    logic [VW-1:0] r;
    for (int b = 0; b < VW/8; b++) begin
      int e;
      bit en;
      e  = b / (1 << ew);
      en = (sel == 0) || m[e];
      r[8*b +: 8] = en ? res[8*b +: 8] : (zero ? 8'h00 : old[8*b +: 8]);
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_mask(int idx, logic [MW-1:0] d);
    mw_en = 1'b1; mw_idx = 3'(idx); mw_data = d;
    @(negedge clk);
    mw_en = 1'b0;
    model[idx] = d;
  endtask

  task automatic run_op(int ew, int sel, bit zero, string req);
    logic [VW-1:0] res, old, exp;
    res = {$urandom, $urandom};
    old = {$urandom, $urandom};
    in_valid = 1'b1; in_result = res; in_old = old;
    in_ew = 2'(ew); in_msel = 3'(sel); in_zero = zero;
    exp = expect_vec(res, old, ew, sel, zero, model[sel]);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R8 valid", {63'd0, out_valid}, 64'd1);
    check(out_vec === exp, req, out_vec, exp);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid === 1'b0, "R10 out_valid", {63'd0, out_valid}, 64'd0);
    check(out_vec === '0, "R10 out_vec", out_vec, 64'd0);
    for (int i = 0; i < 8; i++) begin
      mr_idx = 3'(i); #1;
      check(mr_data === '0, "R10 mask reg", {56'd0, mr_data}, 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R3: register 0 writable and readable
    wr_mask(0, 8'hA5);
    mr_idx = 3'd0; #1;
    check(mr_data === 8'hA5, "R3 reg0 readback", {56'd0, mr_data}, 64'hA5);

    // R2: selector 0 ignores register 0 (all zeros here)
    wr_mask(0, 8'h00);
    run_op(0, 0, 1'b1, "R2 sel0 zeroing, reg0=0");
    run_op(3, 0, 1'b0, "R2 sel0 merging, reg0=0");

    // R7: unused upper bits with 64-bit elements
    wr_mask(1, 8'hFE);
    run_op(3, 1, 1'b1, "R7 upper bits ignored (set)");
    wr_mask(1, 8'h00);
    run_op(3, 1, 1'b1, "R7 upper bits ignored (clear)");
    wr_mask(2, 8'hF0);
    run_op(2, 2, 1'b0, "R7 32-bit width ignores bits 2..7");

    // R8: output holds when idle
    begin
      logic [VW-1:0] held;
      held = out_vec;
      in_result = '1;
      repeat (3) @(negedge clk);
      check(out_vec === held && out_valid === 1'b0, "R8 hold", out_vec, held);
    end

    // R9: same-cycle write and use returns old value
    wr_mask(3, 8'h0F);
    begin
      logic [VW-1:0] res, old, exp;
      res = 64'h1111_2222_3333_4444; old = 64'h9999_8888_7777_6666;
      exp = expect_vec(res, old, 0, 3, 1'b0, 8'h0F);
      mw_en = 1'b1; mw_idx = 3'd3; mw_data = 8'hF0;
      in_valid = 1'b1; in_result = res; in_old = old;
      in_ew = 2'd0; in_msel = 3'd3; in_zero = 1'b0; mr_idx = 3'd3;
      #1;
      check(mr_data === 8'h0F, "R9 read port old", {56'd0, mr_data}, 64'h0F);
      @(negedge clk);
      mw_en = 1'b0; in_valid = 1'b0;
      model[3] = 8'hF0;
      check(out_vec === exp, "R9 predicate old", out_vec, exp);
      check(mr_data === 8'hF0, "R9 new value next cycle", {56'd0, mr_data}, 64'hF0);
    end

    // Exhaustive sweep: R1 R4 R5 R6 R7
    for (int mv = 0; mv < 256; mv++) begin
      for (int k = 0; k < 8; k++) wr_mask(k, 8'(mv) ^ 8'(k * 37));
      for (int ew = 0; ew < 4; ew++)
        for (int sel = 0; sel < 8; sel++)
          for (int z = 0; z < 2; z++)
            run_op(ew, sel, z[0], sel == 0 ? "R2 sweep" :
                   (z != 0 ? "R1 R4 R6 sweep" : "R1 R5 R6 sweep"));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule